// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block is the in-order retirement queue for a core that runs two hardware threads at once. Its entry store is cut into two fixed regions, and each thread's region works as a separate circular queue with its own head, tail and occupancy count. A dispatcher names the thread and supplies an instruction tag. The block answers in the same cycle with an accept flag and the physical entry index it gave out. Execution units later report completion by thread and index. On its own schedule, each thread retires the entry at its head once that entry is complete.

Each thread has a separate full flag and a separate commit path. A long-latency instruction at the head of one thread therefore never holds back the other thread, and a thread that has run out of room never refuses dispatch to its partner. When only one thread is running, a mode input can hand the whole store to thread 0. The block takes on a new mode only in a cycle where both regions are empty.

Top module: `dual_thread_rob`

## Requirements
- R1: After reset both full flags are low, neither thread presents a commit, and no dispatch is accepted while disp_valid is low.
- R2: In split mode (solo_mode=0) each thread owns 16 entries. Thread 0 receives indices 0..15 and thread 1 receives indices 16..31, each handed out in ascending order and wrapping within its own region. A thread's full flag rises when its 16th entry is held.
- R3: A dispatch to a thread whose full flag is high is refused (disp_ack=0) and creates no entry.
- R4: A thread commits only from its head entry, and only once that entry has been marked complete. Entries completed out of order wait until every older entry of the same thread has retired.
- R5: An incomplete head entry in one thread does not delay commit of a completed head entry in the other thread.
- R6: Each full flag depends only on its own thread's occupancy. Filling one thread leaves the other thread's flag low.
- R7: A dispatch and a commit on the same thread in the same cycle leave that thread's occupancy unchanged.
- R8: In solo mode (solo_mode=1 once it has taken effect) thread 0 owns all 32 entries, indices 0..31, and becomes full only at 32 entries. Thread 1 reads full, accepts no dispatch and presents no commit.
- R9: A change on solo_mode takes effect at the first clock edge at which both threads hold no entries. Until then the previous mode stays in force. A dispatch offered in the cycle the mode changes is refused. Both regions restart at their lowest index after a mode change.
- R10: A completion report is ignored when the named entry is not held by an instruction, or when it lies outside the reporting thread's region: upper half for thread 1 and lower half for thread 0 in split mode, and thread 0 only in solo mode.
- R11: Each thread retires at most one entry per cycle, and the committed tag equals the tag given at dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| solo_mode | input | 1 | 1 requests single-thread mode, 0 requests split mode |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | 1 | Thread of the dispatch request |
| disp_tag | input | TAG_W | Instruction tag to store |
| disp_ack | output | 1 | Dispatch accepted this cycle |
| disp_idx | output | IDX_W | Entry index given to the dispatched instruction |
| wb_valid | input | 1 | Completion report |
| wb_tid | input | 1 | Thread of the completion report |
| wb_idx | input | IDX_W | Entry index being marked complete |
| full | output | 2 | Per-thread full flag, bit t for thread t |
| cmt_valid | output | 2 | Per-thread commit this cycle, bit t for thread t |
| cmt_tag0 | output | TAG_W | Tag retiring from thread 0 |
| cmt_tag1 | output | TAG_W | Tag retiring from thread 1 |

## Verification
Dispatch and commit can fall in the same cycle on the same thread, as can commit on both threads at once. The bench makes the first happen by completing only the head of a 15-entry thread 0, then dispatching in exactly the cycle its commit is presented. Occupancy is judged through the full flag: it must stay low after that cycle and rise only after one further dispatch. The isolation case marks a thread 1 entry complete while thread 0's head stays incomplete, and checks that thread 1 commits at the next edge while thread 0 presents nothing.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_SOLO  = 1'b1
  } rob_mode_e;

  typedef struct packed {
    logic busy;
    logic done;
  } rob_flag_t;

endpackage

// File: rtl/rob_thread_ctl.sv
module rob_thread_ctl #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  input  logic [IDX_W-1:0] base,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  function automatic logic [IDX_W-1:0] step_off(input logic [IDX_W-1:0] off,
                                                input logic [CNT_W-1:0] lim);
    if (CNT_W'(off) == lim - 1'b1) return '0;
    return off + 1'b1;
  endfunction

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    upd    = clr | push | pop;
    if (clr) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) tail_d = step_off(tail_q, limit);
      if (pop)  head_d = step_off(head_q, limit);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_idx = base + head_q;
  assign tail_idx = base + tail_q;
  assign count    = cnt_q;
  assign full     = (cnt_q == limit);

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
  import rob_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TAG_W = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic [1:0]       rel_en,
  input  logic [IDX_W-1:0] rel_idx0,
  input  logic [IDX_W-1:0] rel_idx1,
  input  logic [IDX_W-1:0] rd_idx0,
  input  logic [IDX_W-1:0] rd_idx1,
  output logic [TAG_W-1:0] rd_tag0,
  output logic [TAG_W-1:0] rd_tag1,
  output logic [DEPTH-1:0] done_vec
);

  logic [TAG_W-1:0] tag_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_tag0 = tag_mem[rd_idx0];
  assign rd_tag1 = tag_mem[rd_idx1];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    rob_flag_t flag_q, flag_d;
    logic      hit_wr, hit_mark, hit_rel;

    always_comb begin
      hit_wr   = wr_en   && (wr_idx   == IDX_W'(e));
      hit_mark = mark_en && (mark_idx == IDX_W'(e));
      hit_rel  = (rel_en[0] && (rel_idx0 == IDX_W'(e))) ||
                 (rel_en[1] && (rel_idx1 == IDX_W'(e)));
      flag_d = flag_q;
      if (hit_mark && flag_q.busy) flag_d.done = 1'b1;
      if (hit_wr) begin
        flag_d.busy = 1'b1;
        flag_d.done = 1'b0;
      end
      if (hit_rel) flag_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q <= '0;
      else if (hit_wr | hit_mark | hit_rel) flag_q <= flag_d;
    end

    assign done_vec[e] = flag_q.done;
  end

endmodule

// File: rtl/dual_thread_rob.sv
module dual_thread_rob
  import rob_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TAG_W = 8,
  localparam int HALF  = DEPTH / 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             solo_mode,
  input  logic             disp_valid,
  input  logic             disp_tid,
  input  logic [TAG_W-1:0] disp_tag,
  output logic             disp_ack,
  output logic [IDX_W-1:0] disp_idx,
  input  logic             wb_valid,
  input  logic             wb_tid,
  input  logic [IDX_W-1:0] wb_idx,
  output logic [1:0]       full,
  output logic [1:0]       cmt_valid,
  output logic [TAG_W-1:0] cmt_tag0,
  output logic [TAG_W-1:0] cmt_tag1
);

  rob_mode_e        mode_q, mode_d;
  logic             mode_upd, all_empty;
  logic [CNT_W-1:0] cnt      [2];
  logic [IDX_W-1:0] head_idx [2];
  logic [IDX_W-1:0] tail_idx [2];
  logic [CNT_W-1:0] limit    [2];
  logic [IDX_W-1:0] base     [2];
  logic [1:0]       ctl_full, push, pop;
  logic [DEPTH-1:0] done_vec;
  logic             owner_ok, mark_en;
  logic [CNT_W-1:0] cnt_t0, cnt_t1;

  assign cnt_t0 = cnt[0];
  assign cnt_t1 = cnt[1];

  always_comb begin
    all_empty = (cnt[0] == '0) && (cnt[1] == '0);
    mode_upd  = all_empty && (rob_mode_e'(solo_mode) != mode_q);
    mode_d    = mode_upd ? rob_mode_e'(solo_mode) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= MODE_SPLIT;
    else if (mode_upd) mode_q <= mode_d;
  end

  always_comb begin
    limit[0] = (mode_q == MODE_SOLO) ? CNT_W'(DEPTH) : CNT_W'(HALF);
    limit[1] = CNT_W'(HALF);
    base[0]  = '0;
    base[1]  = IDX_W'(HALF);
    full[0]  = ctl_full[0];
    full[1]  = (mode_q == MODE_SOLO) | ctl_full[1];
    disp_ack = disp_valid && !mode_upd && !full[disp_tid];
    disp_idx = tail_idx[disp_tid];
    push[0]  = disp_ack && (disp_tid == 1'b0);
    push[1]  = disp_ack && (disp_tid == 1'b1);
    pop[0]   = (cnt[0] != '0) && done_vec[head_idx[0]];
    pop[1]   = (cnt[1] != '0) && done_vec[head_idx[1]];
    cmt_valid = pop;
    owner_ok = (mode_q == MODE_SOLO) ? (wb_tid == 1'b0)
                                     : (wb_idx[IDX_W-1] == wb_tid);
    mark_en  = wb_valid && owner_ok;
  end

  for (genvar t = 0; t < 2; t++) begin : g_thread
    rob_thread_ctl #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
    ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mode_upd),
      .limit    (limit[t]),
      .base     (base[t]),
      .push     (push[t]),
      .pop      (pop[t]),
      .head_idx (head_idx[t]),
      .tail_idx (tail_idx[t]),
      .count    (cnt[t]),
      .full     (ctl_full[t])
    );
  end

  rob_entry_array #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (disp_ack),
    .wr_idx   (disp_idx),
    .wr_tag   (disp_tag),
    .mark_en  (mark_en),
    .mark_idx (wb_idx),
    .rel_en   (pop),
    .rel_idx0 (head_idx[0]),
    .rel_idx1 (head_idx[1]),
    .rd_idx0  (head_idx[0]),
    .rd_idx1  (head_idx[1]),
    .rd_tag0  (cmt_tag0),
    .rd_tag1  (cmt_tag1),
    .done_vec (done_vec)
  );

endmodule

// File: rtl/rob_checks.sv
module rob_checks #(
  parameter int HALF  = 16,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_tid,
  input logic             disp_ack,
  input logic [IDX_W-1:0] disp_idx,
  input logic [1:0]       full,
  input logic [1:0]       cmt_valid,
  input logic             mode_solo,
  input logic             mode_upd,
  input logic [CNT_W-1:0] cnt_t0,
  input logic [CNT_W-1:0] cnt_t1
);

  a_r3_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && full[disp_tid] |-> !disp_ack);

  a_r2_split_region: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ack && !mode_solo |-> disp_idx[IDX_W-1] == disp_tid);

  a_r8_solo_t1_closed: assert property (@(posedge clk) disable iff (!rst_n)
    mode_solo |-> full[1] && !cmt_valid[1]);

  a_r9_mode_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_t0 != '0 || cnt_t1 != '0) |=> $stable(mode_solo));

  a_r9_no_dispatch_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    mode_upd |-> !disp_ack);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ack && !disp_tid && cmt_valid[0] |=> $stable(cnt_t0));

  a_r6_t0_full_own_count: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_t0 < CNT_W'(HALF) |-> !full[0]);

  a_r6_t1_full_own_count: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_solo && cnt_t1 < CNT_W'(HALF) |-> !full[1]);

endmodule

bind dual_thread_rob rob_checks #(
  .HALF  (HALF),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_tid   (disp_tid),
  .disp_ack   (disp_ack),
  .disp_idx   (disp_idx),
  .full       (full),
  .cmt_valid  (cmt_valid),
  .mode_solo  (mode_q == rob_pkg::MODE_SOLO),
  .mode_upd   (mode_upd),
  .cnt_t0     (cnt_t0),
  .cnt_t1     (cnt_t1)
);

// File: tb/dual_thread_rob_tb.sv
module dual_thread_rob_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int TAG_W = 8;
  localparam int HALF  = DEPTH / 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk;
  logic             rst_n;
  logic             solo_mode;
  logic             disp_valid;
  logic             disp_tid;
  logic [TAG_W-1:0] disp_tag;
  logic             disp_ack;
  logic [IDX_W-1:0] disp_idx;
  logic             wb_valid;
  logic             wb_tid;
  logic [IDX_W-1:0] wb_idx;
  logic [1:0]       full;
  logic [1:0]       cmt_valid;
  logic [TAG_W-1:0] cmt_tag0;
  logic [TAG_W-1:0] cmt_tag1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int off0 = 0;
  int off1 = 0;
  int lim0 = HALF;
  int qi0[$];
  int qt0[$];
  int qi1[$];
  int qt1[$];

  dual_thread_rob #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .solo_mode  (solo_mode),
    .disp_valid (disp_valid),
    .disp_tid   (disp_tid),
    .disp_tag   (disp_tag),
    .disp_ack   (disp_ack),
    .disp_idx   (disp_idx),
    .wb_valid   (wb_valid),
    .wb_tid     (wb_tid),
    .wb_idx     (wb_idx),
    .full       (full),
    .cmt_valid  (cmt_valid),
    .cmt_tag0   (cmt_tag0),
    .cmt_tag1   (cmt_tag1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic dispatch(input int t, input int tag, input bit exp_ack, input string req);
    int exp_idx;
    exp_idx = (t == 0) ? off0 : (HALF + off1);
    disp_valid = 1'b1;
    disp_tid   = t[0];
    disp_tag   = tag[TAG_W-1:0];
    #1;
    chk(req, "disp_ack", int'(disp_ack), int'(exp_ack));
    if (exp_ack) begin
      chk(req, "disp_idx", int'(disp_idx), exp_idx);
      if (t == 0) begin
        qi0.push_back(exp_idx); qt0.push_back(tag);
        off0 = (off0 + 1 == lim0) ? 0 : off0 + 1;
      end else begin
        qi1.push_back(exp_idx); qt1.push_back(tag);
        off1 = (off1 + 1 == HALF) ? 0 : off1 + 1;
      end
    end
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic wb(input int t, input int idx);
    wb_valid = 1'b1;
    wb_tid   = t[0];
    wb_idx   = idx[IDX_W-1:0];
    tick();
    wb_valid = 1'b0;
  endtask

  task automatic drain(input int t, input string req);
    if (t == 0) begin
      while (qi0.size() > 0) begin
        wb(0, qi0[0]);
        chk(req, "cmt_valid0", int'(cmt_valid[0]), 1);
        chk(req, "cmt_tag0", int'(cmt_tag0), qt0[0]);
        void'(qi0.pop_front()); void'(qt0.pop_front());
      end
      tick();
      chk(req, "cmt_valid0 after drain", int'(cmt_valid[0]), 0);
    end else begin
      while (qi1.size() > 0) begin
        wb(1, qi1[0]);
        chk(req, "cmt_valid1", int'(cmt_valid[1]), 1);
        chk(req, "cmt_tag1", int'(cmt_tag1), qt1[0]);
        void'(qi1.pop_front()); void'(qt1.pop_front());
      end
      tick();
      chk(req, "cmt_valid1 after drain", int'(cmt_valid[1]), 0);
    end
  endtask

  task automatic t_reset();
    chk("R1", "full", int'(full), 0);
    chk("R1", "cmt_valid", int'(cmt_valid), 0);
    chk("R1", "disp_ack idle", int'(disp_ack), 0);
  endtask

  task automatic t_split_fill();
    for (int i = 0; i < HALF; i++) dispatch(0, 1 + i, 1'b1, "R2");
    chk("R2", "full0 at 16", int'(full[0]), 1);
    chk("R6", "full1 while t0 full", int'(full[1]), 0);
    dispatch(0, 99, 1'b0, "R3");
    dispatch(1, 200, 1'b1, "R2");
    chk("R6", "full1 one entry", int'(full[1]), 0);
    drain(0, "R3");
    chk("R3", "full0 after drain", int'(full[0]), 0);
    drain(1, "R2");
  endtask

  task automatic t_order();
    dispatch(0, 11, 1'b1, "R4");
    dispatch(0, 12, 1'b1, "R4");
    dispatch(0, 13, 1'b1, "R4");
    wb(0, qi0[2]);
    chk("R4", "youngest done only", int'(cmt_valid[0]), 0);
    wb(0, qi0[1]);
    chk("R4", "head still open", int'(cmt_valid[0]), 0);
    wb(0, qi0[0]);
    chk("R4", "head commit", int'(cmt_valid[0]), 1);
    chk("R4", "head tag", int'(cmt_tag0), 11);
    tick();
    chk("R11", "second commit", int'(cmt_valid[0]), 1);
    chk("R11", "second tag", int'(cmt_tag0), 12);
    tick();
    chk("R11", "third tag", int'(cmt_tag0), 13);
    tick();
    chk("R11", "queue empty", int'(cmt_valid[0]), 0);
    qi0.delete(); qt0.delete();
  endtask

  task automatic t_isolate();
    dispatch(0, 21, 1'b1, "R5");
    dispatch(1, 22, 1'b1, "R5");
    wb(1, qi1[0]);
    chk("R5", "t1 commits", int'(cmt_valid[1]), 1);
    chk("R5", "t1 tag", int'(cmt_tag1), 22);
    chk("R5", "t0 blocked", int'(cmt_valid[0]), 0);
    tick();
    chk("R5", "t1 retired", int'(cmt_valid[1]), 0);
    qi1.delete(); qt1.delete();
    drain(0, "R5");
  endtask

  task automatic t_wb_ignore();
    int next1;
    dispatch(0, 31, 1'b1, "R10");
    wb(1, qi0[0]);
    chk("R10", "foreign wb ignored", int'(cmt_valid[0]), 0);
    next1 = HALF + off1;
    wb(1, next1);
    dispatch(1, 32, 1'b1, "R10");
    chk("R10", "wb to free entry ignored", int'(cmt_valid[1]), 0);
    tick();
    chk("R10", "still not done", int'(cmt_valid[1]), 0);
    drain(0, "R10");
    drain(1, "R10");
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < HALF - 1; i++) dispatch(0, 40 + i, 1'b1, "R7");
    wb(0, qi0[0]);
    chk("R7", "head ready", int'(cmt_valid[0]), 1);
    chk("R7", "head tag", int'(cmt_tag0), 40);
    void'(qi0.pop_front()); void'(qt0.pop_front());
    dispatch(0, 60, 1'b1, "R7");
    chk("R7", "full0 after push+pop", int'(full[0]), 0);
    chk("R7", "no further commit", int'(cmt_valid[0]), 0);
    dispatch(0, 61, 1'b1, "R7");
    chk("R7", "full0 after one more", int'(full[0]), 1);
    drain(0, "R7");
  endtask

  task automatic t_solo();
    dispatch(0, 70, 1'b1, "R9");
    solo_mode = 1'b1;
    tick(); tick();
    chk("R9", "mode held while busy", int'(full[1]), 0);
    dispatch(1, 71, 1'b1, "R9");
    drain(0, "R9");
    drain(1, "R9");
    tick();
    off0 = 0; off1 = 0; lim0 = DEPTH;
    chk("R8", "t1 closed in solo", int'(full[1]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      dispatch(0, 100 + i, 1'b1, "R8");
      if (i == HALF - 1) chk("R8", "full0 at 16 in solo", int'(full[0]), 0);
    end
    chk("R8", "full0 at 32", int'(full[0]), 1);
    dispatch(1, 5, 1'b0, "R8");
    drain(0, "R8");
    solo_mode = 1'b0;
    tick(); tick();
    off0 = 0; off1 = 0; lim0 = HALF;
    chk("R9", "split restored", int'(full[1]), 0);
    dispatch(1, 9, 1'b1, "R9");
    drain(1, "R9");
  endtask

  initial begin
    rst_n = 1'b0;
    solo_mode = 1'b0;
    disp_valid = 1'b0;
    disp_tid = 1'b0;
    disp_tag = '0;
    wb_valid = 1'b0;
    wb_tid = 1'b0;
    wb_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_split_fill();
    t_order();
    t_isolate();
    t_wb_ignore();
    t_same_cycle();
    t_solo();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule